// File: doc/BRIEF.md
# Sensitivity-Based Request Steering Filter

This block sits in front of the last-level cache and picks a target for every incoming memory request. The target is either the shared last-level cache or a separate buffer that only GPU traffic may use. Each request carries a one-bit origin flag. CPU requests always go to the shared cache. GPU requests are steered by a classification of GPU cache sensitivity.

The classification comes from a per-cycle count of active warps, which the upper-level cache supplies. The block averages that count over a programmable interval. A high average means enough thread parallelism to hide memory latency, so the GPU is cache insensitive. A low average means the GPU is cache sensitive. No divider is used: the interval sum is compared against the threshold multiplied by the number of samples.

Routing is a one-stage pipeline with a valid/ready handshake. Each response carries the request tag and a target bit. The current classification is also available as an output.

Top module: `steer_filter`

## Requirements
- R1: A CPU request (origin flag 0) always comes out with target bit 0, meaning the shared cache.
- R2: A GPU request (origin flag 1) comes out with target bit 1, meaning the GPU-only buffer, exactly when `gpu_insens` was 1 in the cycle the request was accepted. Otherwise its target bit is 0.
- R3: At the end of each interval, `gpu_insens` becomes 1 if the sum of the interval's warp samples is strictly greater than THRESH (40) times the number of samples. Otherwise it becomes 0.
- R4: An interval whose average is exactly THRESH classifies the GPU as sensitive (`gpu_insens` = 0).
- R5: During reset and after it, `gpu_insens` is 0 until the first interval completes. `rsp_valid` is 0 after reset.
- R6: A warp sample is taken on every clock edge after reset. An interval ends on the edge that takes its `intv_len`-th sample, and the new status is visible right after that edge. An `intv_len` of 0 behaves as 1.
- R7: Warp samples above MAX_WARPS (48) count as MAX_WARPS.
- R8: A request accepted on an edge (`req_valid` and `req_ready` both 1) appears on `rsp_valid` after that edge, with `rsp_tag` equal to its tag.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds steady and `req_ready` is 0. `req_ready` equals `!rsp_valid || rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intv_len | input | INTV_W | Samples per classification interval (0 acts as 1) |
| warp_cnt | input | WARP_W | Active warp count sampled every cycle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_gpu | input | 1 | Origin flag: 1 for GPU, 0 for CPU |
| req_tag | input | TAG_W | Request tag |
| rsp_valid | output | 1 | Routed request present |
| rsp_ready | input | 1 | Downstream takes the routed request |
| rsp_tag | output | TAG_W | Tag of the routed request |
| rsp_to_buf | output | 1 | Target bit: 1 for the GPU buffer, 0 for the shared cache |
| gpu_insens | output | 1 | Current classification: 1 means cache insensitive |

## Verification
Random warp samples are drawn from a band centred on the threshold, so the sum-versus-limit comparison falls on both sides from one interval to the next. Interval lengths are random and include 0 and 1. The origin flag and backpressure are also random, which separates origin-based routing from status-based routing and exercises the hold behaviour. Directed cases cover these points:
- An interval averaging exactly 40 separates a strict comparison from an inclusive one.
- The samples 63 and 20 are classified differently with and without clamping.
- Reset is applied again in the middle of an interval that is classified insensitive.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic {
    TGT_LLC = 1'b0,
    TGT_BUF = 1'b1
  } target_e;

  function automatic target_e pick_target(input logic is_gpu, input logic insens);
    return (is_gpu && insens) ? TGT_BUF : TGT_LLC;
  endfunction
endpackage

// File: rtl/warp_accum.sv
module warp_accum #(
  parameter int WARP_W    = 6,
  parameter int INTV_W    = 16,
  parameter int MAX_WARPS = 48,
  localparam int SUM_W    = WARP_W + INTV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WARP_W-1:0] sample,
  input  logic [INTV_W-1:0] len,
  output logic              done,
  output logic [SUM_W-1:0]  total,
  output logic [INTV_W-1:0] eff_len
);
  localparam int MAXV = (2 ** WARP_W) - 1;

  logic [SUM_W-1:0]  sum_q;
  logic [INTV_W-1:0] cnt_q;
  logic [WARP_W-1:0] sat;

  generate
    if (MAX_WARPS >= MAXV) begin : g_noclamp
      assign sat = sample;
    end else begin : g_clamp
      assign sat = (sample > WARP_W'(MAX_WARPS)) ? WARP_W'(MAX_WARPS) : sample;
    end
  endgenerate

  assign eff_len = (len == '0) ? INTV_W'(1) : len;
  assign total   = sum_q + SUM_W'(sat);
  assign done    = ({1'b0, cnt_q} + (INTV_W+1)'(1)) >= {1'b0, eff_len};

  always_ff @(posedge clk) begin
    if (rst || done) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else begin
      sum_q <= total;
      cnt_q <= cnt_q + INTV_W'(1);
    end
  end
endmodule

// File: rtl/sens_classifier.sv
module sens_classifier #(
  parameter int WARP_W = 6,
  parameter int INTV_W = 16,
  parameter int THRESH = 40,
  localparam int SUM_W = WARP_W + INTV_W,
  localparam int THR_W = $clog2(THRESH + 1),
  localparam int CMP_W = ((SUM_W > THR_W + INTV_W) ? SUM_W : THR_W + INTV_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [SUM_W-1:0]  total,
  input  logic [INTV_W-1:0] eff_len,
  output logic              insens
);
  logic [CMP_W-1:0] limit;
  logic [CMP_W-1:0] total_x;

  assign limit   = CMP_W'(THRESH) * CMP_W'(eff_len);
  assign total_x = CMP_W'(total);

  always_ff @(posedge clk) begin
    if (rst) begin
      insens <= 1'b0;
    end else if (done) begin
      insens <= (total_x > limit);
    end
  end
endmodule

// File: rtl/route_stage.sv
module route_stage
  import steer_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insens,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_gpu,
  input  logic [TAG_W-1:0] req_tag,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [TAG_W-1:0] rsp_tag,
  output logic             rsp_to_buf
);
  logic take;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_tag    <= '0;
      rsp_to_buf <= 1'b0;
    end else if (take) begin
      rsp_valid  <= 1'b1;
      rsp_tag    <= req_tag;
      rsp_to_buf <= (pick_target(req_gpu, insens) == TGT_BUF);
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/steer_filter.sv
module steer_filter #(
  parameter int WARP_W    = 6,
  parameter int INTV_W    = 16,
  parameter int TAG_W     = 8,
  parameter int THRESH    = 40,
  parameter int MAX_WARPS = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INTV_W-1:0] intv_len,
  input  logic [WARP_W-1:0] warp_cnt,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_gpu,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_to_buf,
  output logic              gpu_insens
);
  localparam int SUM_W = WARP_W + INTV_W;

  logic              done;
  logic [SUM_W-1:0]  total;
  logic [INTV_W-1:0] eff_len;

  warp_accum #(.WARP_W(WARP_W), .INTV_W(INTV_W), .MAX_WARPS(MAX_WARPS)) u_acc (
    .clk(clk), .rst(rst), .sample(warp_cnt), .len(intv_len),
    .done(done), .total(total), .eff_len(eff_len)
  );

  sens_classifier #(.WARP_W(WARP_W), .INTV_W(INTV_W), .THRESH(THRESH)) u_cls (
    .clk(clk), .rst(rst), .done(done), .total(total), .eff_len(eff_len),
    .insens(gpu_insens)
  );

  route_stage #(.TAG_W(TAG_W)) u_rt (
    .clk(clk), .rst(rst), .insens(gpu_insens),
    .req_valid(req_valid), .req_ready(req_ready), .req_gpu(req_gpu), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_to_buf(rsp_to_buf)
  );
endmodule

// File: rtl/steer_filter_chk.sv
module steer_filter_chk #(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_gpu,
  input logic [TAG_W-1:0] req_tag,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [TAG_W-1:0] rsp_tag,
  input logic             rsp_to_buf,
  input logic             gpu_insens
);
  AST_RESET_SENSITIVE: assert property (@(posedge clk) rst |=> !gpu_insens && !rsp_valid); // R5
  AST_CPU_TO_LLC: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !req_gpu |=> rsp_valid && !rsp_to_buf); // R1
  AST_GPU_ROUTE: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_gpu |=> rsp_to_buf == $past(gpu_insens)); // R2
  AST_TAG_PASS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rsp_valid && rsp_tag == $past(req_tag)); // R8
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_tag) && $stable(rsp_to_buf)); // R9
  AST_NO_ACCEPT_STALL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |-> !req_ready); // R9
endmodule

bind steer_filter steer_filter_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_gpu(req_gpu),
  .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag),
  .rsp_to_buf(rsp_to_buf), .gpu_insens(gpu_insens)
);

// File: tb/tb_steer_filter.sv
`timescale 1ns/1ps
module tb_steer_filter;
  localparam int WARP_W = 6, INTV_W = 16, TAG_W = 8, THRESH = 40, MAXW = 48;

  logic clk = 0, rst = 1;
  logic [INTV_W-1:0] intv_len = 1;
  logic [WARP_W-1:0] warp_cnt = 0;
  logic req_valid = 0, req_gpu = 0, rsp_ready = 0;
  logic [TAG_W-1:0] req_tag = 0;
  logic req_ready, rsp_valid, rsp_to_buf, gpu_insens;
  logic [TAG_W-1:0] rsp_tag;

  always #2 clk = ~clk;

  steer_filter #(.WARP_W(WARP_W), .INTV_W(INTV_W), .TAG_W(TAG_W), .THRESH(THRESH), .MAX_WARPS(MAXW)) dut (
    .clk(clk), .rst(rst), .intv_len(intv_len), .warp_cnt(warp_cnt),
    .req_valid(req_valid), .req_ready(req_ready), .req_gpu(req_gpu), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag),
    .rsp_to_buf(rsp_to_buf), .gpu_insens(gpu_insens)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  // reference model state
  int m_sum = 0, m_cnt = 0;
  bit m_ins = 0, m_v = 0, m_buf = 0, m_gpu = 0;
  int m_tag = 0;
  string ins_req = "R3";

  function automatic int clampw(input int w);
    return (w > MAXW) ? MAXW : w;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs();
    chk(ins_req, gpu_insens, m_ins);
    chk("R8", rsp_valid, m_v);
    if (m_v) begin
      chk("R8", rsp_tag, m_tag);
      chk(m_gpu ? "R2" : "R1", rsp_to_buf, m_buf);
    end
  endtask

  // called at a negedge: drive, check ready, advance model, then check at next negedge
  task automatic cyc(input bit v, input bit g, input int tag, input bit rdy, input int w, input int len);
    int l, s;
    bit take;
    req_valid = v; req_gpu = g; req_tag = TAG_W'(tag); rsp_ready = rdy;
    warp_cnt = WARP_W'(w); intv_len = INTV_W'(len);
    #0.5;
    chk("R9", req_ready, (!m_v || rdy));
    take = v && (!m_v || rdy);
    if (take) begin
      m_v = 1; m_tag = tag; m_gpu = g; m_buf = g && m_ins;
    end else if (rdy) m_v = 0;
    l = (len == 0) ? 1 : len;
    s = clampw(w);
    if (m_cnt + 1 >= l) begin
      m_ins = (m_sum + s) > THRESH * l;
      m_sum = 0; m_cnt = 0;
    end else begin
      m_sum += s; m_cnt++;
    end
    @(posedge clk); @(negedge clk);
    check_outs();
  endtask

  task automatic do_reset();
    rst = 1; req_valid = 0; rsp_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_sum = 0; m_cnt = 0; m_ins = 0; m_v = 0;
    chk("R5", gpu_insens, 0);
    chk("R5", rsp_valid, 0);
    rst = 0;
  endtask

  initial begin
    #(4.0 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    do_reset();
    // R5: stays sensitive before first interval ends (high warps, long interval)
    ins_req = "R5";
    for (int i = 0; i < 5; i++) cyc(1, 1, i, 1, 48, 8);
    // R6: status flips right after the 8th sample
    ins_req = "R6";
    for (int i = 0; i < 4; i++) cyc(1, 1, 10 + i, 1, 48, 8);
    // R4: exact average of 40 -> sensitive
    ins_req = "R4";
    for (int i = 0; i < 4; i++) cyc(1, 1, 20 + i, 1, 40, 4);
    // R3: just above threshold
    ins_req = "R3";
    cyc(1, 0, 30, 1, 41, 2); cyc(1, 1, 31, 1, 40, 2);
    cyc(1, 1, 32, 1, 40, 2); cyc(1, 1, 33, 1, 40, 2);
    // R7: 63 clamps to 48; 48+20=68 <= 80 -> sensitive (unclamped would be insensitive)
    ins_req = "R7";
    cyc(1, 1, 40, 1, 63, 2); cyc(1, 1, 41, 1, 20, 2); cyc(1, 1, 42, 1, 40, 2);
    // R6: length 0 acts as 1
    ins_req = "R6";
    cyc(1, 1, 50, 1, 45, 0); cyc(1, 1, 51, 1, 10, 0); cyc(1, 1, 52, 1, 41, 0);
    // R9: stall holds response
    cyc(1, 1, 60, 0, 41, 1); cyc(1, 0, 61, 0, 41, 1); cyc(1, 0, 62, 1, 41, 1);
    cyc(0, 0, 63, 1, 41, 1);
    // R5: reset mid-interval while insensitive
    cyc(1, 1, 70, 1, 48, 1);
    do_reset();
    ins_req = "R5";
    cyc(1, 1, 71, 1, 48, 3);
    // random mix
    ins_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      int w, len;
      w = ($urandom % 16 == 0) ? 63 : 30 + int'($urandom % 21);
      len = int'($urandom % 9);
      if (i % 50 == 0) len = 0;
      cyc($urandom % 4 != 0, $urandom % 2, int'($urandom % 256), $urandom % 3 != 0, w, len);
    end
    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule